// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo stream of two's-complement audio samples arriving one bit at a time, most significant bit first, and turns each left/right pair into two parallel 24-bit words. A frame clock splits every frame into a left half and a right half. Bits are taken either on the rising edges of an external bit clock or, when no bit clock is toggling, on a bit clock the block derives from its own master clock at 64 bits per frame. A 3-bit format code picks the word length and whether the word sits at the end (right-justified) or the start (left-justified) of each half-frame.

All inputs are sampled in the master-clock domain, which runs at 256 or 384 times the frame rate. The block decides again at every frame boundary which bit-clock source to use and shows that choice on a status output. After reset it waits a configurable number of frames, standing in for the converter's calibration time, before it raises a ready flag and begins to deliver sample pairs, each marked by a one-cycle strobe.

Top module: `aud_ser_rx`

## Requirements
- R1: A frame-clock high level marks the left channel and a low level the right channel; serial bits are taken most significant first, and a pair is made of a left half followed by the right half that comes after it.
- R2: Format codes 0, 2 and 1 take right-justified words of 16, 20 and 24 bits: the word's last bit is the last bit taken before the frame clock changes, and any earlier bits in that half are ignored.
- R3: Format codes 3 and 4 both take a 24-bit left-justified word: the first 24 bits after a frame-clock change form the word, and later bits in that half are ignored.
- R4: Words shorter than 24 bits are sign-extended to fill the 24-bit outputs.
- R5: `pair_valid` pulses for exactly one cycle, only in the cycle after a frame-clock rising edge (the end of a right half) is seen, and it updates `left_out` and `right_out` at the same time; both outputs hold their values at all other times.
- R6: `ext_bclk_mode` is updated only on a frame-clock rising edge: it becomes 1 if the bit-clock input changed level at least twice during the frame that ended, and 0 otherwise (a single change or none).
- R7: While `ext_bclk_mode` is 1, a bit is taken on each rising edge of the bit-clock input.
- R8: While `ext_bclk_mode` is 0, a bit is taken every 4 master clocks (`ratio_384`=0) or every 6 master clocks (`ratio_384`=1), with the bit windows aligned to frame-clock edges, giving 32 bits per half-frame.
- R9: `rx_ready` rises on the HOLDOFF_FRAMES-th frame-clock rising edge after reset and stays high; `pair_valid` never pulses while `rx_ready` is low.
- R10: Format codes 5, 6 and 7 are reserved: no `pair_valid` pulse is produced and the sample outputs keep their values.
- R11: After reset, `left_out` and `right_out` are 0 and `pair_valid`, `rx_ready` and `ext_bclk_mode` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 or 384 times the frame rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_384 | input | 1 | Master-clock ratio: 0 = 256 per frame, 1 = 384 per frame |
| fmt_sel | input | 3 | Format code: 0/1/2 right-justified 16/24/20 bit, 3/4 left-justified 24 bit, 5-7 reserved |
| bclk_in | input | 1 | External bit clock; hold at a fixed level to use the internal bit clock |
| fclk_in | input | 1 | Frame clock; high = left half, low = right half |
| sdat_in | input | 1 | Serial data, MSB first |
| left_out | output | 24 | Last complete left sample, sign-extended |
| right_out | output | 24 | Last complete right sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe when a new pair appears on the outputs |
| ext_bclk_mode | output | 1 | 1 when bits are taken on the external bit clock |
| rx_ready | output | 1 | High once the start-up holdoff is over |

## Verification
The bench builds the receiver with HOLDOFF_FRAMES set to 3 in place of the default 2700. At 256 master clocks per frame the default holdoff alone would take about 690,000 cycles, so the short setting lets the bench watch the ready flag rise, with no strobe before it, and then go on to every format, both master-clock ratios, a switch to external bit clocking and back, and the reserved codes. The external bit clock runs at 6 master clocks per bit while the ratio input selects 4, so a correct word in external mode shows that the external edges were used and not the internal ones.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;

  localparam int SMP_W = 24;

  // Codes 0..4 carry audio; 5..7 are reserved.
  function automatic logic fmt_supported(input logic [2:0] f);
    return (f <= 3'd4);
  endfunction

  function automatic logic fmt_is_left(input logic [2:0] f);
    return (f == 3'd3) || (f == 3'd4);
  endfunction

  // Word length of the right-justified codes.
  function automatic int rj_bits(input logic [2:0] f);
    case (f)
      3'd0:    return 16;
      3'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // Keep the low nbits and copy bit nbits-1 upward.
  function automatic logic [SMP_W-1:0] sign_fill(input logic [SMP_W-1:0] raw,
                                                 input int nbits);
    logic [SMP_W-1:0] up;
    up = raw << (SMP_W - nbits);
    return $signed(up) >>> (SMP_W - nbits);
  endfunction

  // Internal bit clock: master clocks to the sample point and per bit.
  function automatic logic [2:0] mid_count(input logic r384);
    return r384 ? 3'd3 : 3'd2;
  endfunction

  function automatic logic [2:0] last_count(input logic r384);
    return r384 ? 3'd5 : 3'd3;
  endfunction

endpackage

// File: rtl/aud_ser_rx_edge.sv
module aud_ser_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      prev  <= 1'b0;
    end else begin
      level <= din;
      prev  <= level;
    end
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/aud_ser_rx_mode.sv
module aud_ser_rx_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_toggle,
  input  logic frame_rise,
  output logic ext_mode
);
  logic [1:0] tog_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_cnt  <= 2'd0;
      ext_mode <= 1'b0;
    end else if (frame_rise) begin
      ext_mode <= (tog_cnt == 2'd2);
      tog_cnt  <= {1'b0, bclk_toggle};
    end else if (bclk_toggle && tog_cnt != 2'd2) begin
      tog_cnt <= tog_cnt + 2'd1;
    end
  end
endmodule

// File: rtl/aud_ser_rx_bitgen.sv
module aud_ser_rx_bitgen
  import aud_ser_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ratio_384,
  input  logic frame_edge,
  output logic tick
);
  logic [2:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 3'd0;
    end else if (frame_edge) begin
      phase <= 3'd1;
    end else if (phase >= last_count(ratio_384)) begin
      phase <= 3'd0;
    end else begin
      phase <= phase + 3'd1;
    end
  end

  assign tick = !frame_edge && (phase == mid_count(ratio_384));
endmodule

// File: rtl/aud_ser_rx_deser.sv
module aud_ser_rx_deser
  import aud_ser_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             frame_edge,
  input  logic [2:0]       fmt_sel,
  output logic [SMP_W-1:0] word_now
);
  localparam int CNT_W = $clog2(SMP_W + 1);

  logic [SMP_W-1:0] shreg;
  logic [SMP_W-1:0] head_word;
  logic [CNT_W-1:0] bit_cnt;
  logic             head_done;

  assign head_done = shift_en && !frame_edge && (bit_cnt == CNT_W'(SMP_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      head_word <= '0;
      bit_cnt   <= '0;
    end else begin
      if (shift_en) shreg <= {shreg[SMP_W-2:0], bit_in};
      if (head_done) head_word <= {shreg[SMP_W-2:0], bit_in};
      if (frame_edge) begin
        bit_cnt <= shift_en ? CNT_W'(1) : '0;
      end else if (shift_en && bit_cnt < CNT_W'(SMP_W)) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // Word of the half-frame that ends now (read before this cycle's shift).
  assign word_now = fmt_is_left(fmt_sel) ? head_word
                                         : sign_fill(shreg, rj_bits(fmt_sel));
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_ser_rx_pkg::*;
#(
  parameter int HOLDOFF_FRAMES = 2700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ratio_384,
  input  logic [2:0]       fmt_sel,
  input  logic             bclk_in,
  input  logic             fclk_in,
  input  logic             sdat_in,
  output logic [SMP_W-1:0] left_out,
  output logic [SMP_W-1:0] right_out,
  output logic             pair_valid,
  output logic             ext_bclk_mode,
  output logic             rx_ready
);
  localparam int HCNT_W = $clog2(HOLDOFF_FRAMES + 1);

  logic             fclk_lvl, frame_rise, frame_fall, frame_edge;
  logic             bclk_lvl, bclk_rise, bclk_fall, bclk_toggle;
  logic             sdat_s;
  logic             int_tick, shift_en;
  logic [SMP_W-1:0] word_now;
  logic [SMP_W-1:0] left_hold;
  logic             have_left;
  logic [HCNT_W-1:0] frame_cnt;

  aud_ser_rx_edge u_fclk (
    .clk(clk), .rst_n(rst_n), .din(fclk_in),
    .level(fclk_lvl), .rise(frame_rise), .fall(frame_fall)
  );

  aud_ser_rx_edge u_bclk (
    .clk(clk), .rst_n(rst_n), .din(bclk_in),
    .level(bclk_lvl), .rise(bclk_rise), .fall(bclk_fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sdat_s <= 1'b0;
    else        sdat_s <= sdat_in;
  end

  assign frame_edge  = frame_rise | frame_fall;
  assign bclk_toggle = bclk_rise | bclk_fall;

  aud_ser_rx_mode u_mode (
    .clk(clk), .rst_n(rst_n), .bclk_toggle(bclk_toggle),
    .frame_rise(frame_rise), .ext_mode(ext_bclk_mode)
  );

  aud_ser_rx_bitgen u_bitgen (
    .clk(clk), .rst_n(rst_n), .ratio_384(ratio_384),
    .frame_edge(frame_edge), .tick(int_tick)
  );

  assign shift_en = ext_bclk_mode ? bclk_rise : int_tick;

  aud_ser_rx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sdat_s),
    .frame_edge(frame_edge), .fmt_sel(fmt_sel), .word_now(word_now)
  );

  // Start-up holdoff counted in frame-clock rising edges.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      rx_ready  <= 1'b0;
    end else if (frame_rise && !rx_ready) begin
      frame_cnt <= frame_cnt + 1'b1;
      if (frame_cnt == HCNT_W'(HOLDOFF_FRAMES - 1)) rx_ready <= 1'b1;
    end
  end

  // Left half ends on a falling edge, the pair ends on a rising edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold  <= '0;
      have_left  <= 1'b0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (frame_fall) begin
        left_hold <= word_now;
        have_left <= 1'b1;
      end
      if (frame_rise) begin
        have_left <= 1'b0;
        if (have_left && rx_ready && fmt_supported(fmt_sel)) begin
          left_out   <= left_hold;
          right_out  <= word_now;
          pair_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_sel,
  input logic        frame_rise,
  input logic [23:0] left_out,
  input logic [23:0] right_out,
  input logic        pair_valid,
  input logic        ext_bclk_mode,
  input logic        rx_ready
);
  // R5
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);
  // R5
  a_r5_after_frame_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(frame_rise));
  // R5
  a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rise |=> ($stable(left_out) && $stable(right_out)));
  // R6
  a_r6_mode_at_frame_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rise |=> $stable(ext_bclk_mode));
  // R9
  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> rx_ready);
  // R9
  a_r9_no_strobe_early: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> rx_ready);
  // R10
  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(fmt_sel) <= 3'd4));
endmodule

bind aud_ser_rx aud_ser_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .frame_rise(frame_rise),
  .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid),
  .ext_bclk_mode(ext_bclk_mode), .rx_ready(rx_ready)
);

// File: tb/aud_ser_rx_tb.sv
`timescale 1ns/1ps
module aud_ser_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio_384 = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        bclk_in = 1'b0;
  logic        fclk_in = 1'b0;
  logic        sdat_in = 1'b0;
  logic [23:0] left_out, right_out;
  logic        pair_valid, ext_bclk_mode, rx_ready;

  int total = 0;
  int bad = 0;
  int vcnt = 0;
  int early = 0;
  int cyc = 0;
  logic [23:0] last_l = '0;
  logic [23:0] last_r = '0;

  aud_ser_rx #(.HOLDOFF_FRAMES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ratio_384(ratio_384), .fmt_sel(fmt_sel),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .sdat_in(sdat_in),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid),
    .ext_bclk_mode(ext_bclk_mode), .rx_ready(rx_ready)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      vcnt++;
      last_l = left_out;
      last_r = right_out;
      if (!rx_ready) early++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [23:0] w, input int i,
                                   input logic [2:0] f);
    logic [23:0] t;
    int len;
    if (f == 3'd3 || f == 3'd4) begin
      if (i >= 24) return i[0];
      t = w >> (23 - i);
      return t[0];
    end
    len = (f == 3'd0) ? 16 : (f == 3'd2) ? 20 : 24;
    if (i < 32 - len) return i[0];
    t = w >> (31 - i);
    return t[0];
  endfunction

  function automatic logic [23:0] exp_word(input logic [23:0] w, input logic [2:0] f);
    case (f)
      3'd0:    return {{8{w[15]}}, w[15:0]};
      3'd2:    return {{4{w[19]}}, w[19:0]};
      default: return w;
    endcase
  endfunction

  // One frame: left half (frame clock high) then right half.
  task automatic send_frame(input logic [23:0] lw, input logic [23:0] rw,
                            input int bitw, input bit ext);
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < 32; i++) begin
        for (int c = 0; c < bitw; c++) begin
          @(negedge clk);
          if (c == 0) begin
            fclk_in = (h == 0);
            sdat_in = exp_bit((h == 0) ? lw : rw, i, fmt_sel);
          end
          bclk_in = ext && (c >= bitw / 2);
        end
      end
    end
  endtask

  task automatic run_pair(input logic [2:0] f, input logic [23:0] lw,
                          input logic [23:0] rw, input int bitw, input bit ext,
                          input string req);
    int v0;
    fmt_sel = f;
    v0 = vcnt;
    send_frame(lw, rw, bitw, ext);
    send_frame(24'h13579B, 24'h2468AC, bitw, ext);
    chk(last_l == exp_word(lw, f), {req, " left word"}, last_l, exp_word(lw, f));
    chk(last_r == exp_word(rw, f), {req, " right word"}, last_r, exp_word(rw, f));
    chk(vcnt - v0 == 2, {req, " R5 one strobe per frame"}, vcnt - v0, 2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(left_out == 0 && right_out == 0, "R11 sample outputs", {8'd0, left_out}, 0);
    chk(pair_valid == 0, "R11 strobe low", pair_valid, 0);
    chk(rx_ready == 0, "R11 ready low", rx_ready, 0);
    chk(ext_bclk_mode == 0, "R11 mode internal", ext_bclk_mode, 0);
  endtask

  task automatic t_holdoff;
    send_frame(24'h000111, 24'h000222, 4, 0);
    send_frame(24'h000333, 24'h000444, 4, 0);
    chk(rx_ready == 0, "R9 ready low before 3rd frame edge", rx_ready, 0);
    send_frame(24'h000555, 24'h000666, 4, 0);
    chk(rx_ready == 1, "R9 ready high after 3rd frame edge", rx_ready, 1);
    chk(vcnt == 0 && early == 0, "R9 no strobe before ready", vcnt + early, 0);
  endtask

  task automatic t_formats;
    run_pair(3'd0, 24'hFF8001, 24'h007FFE, 4, 0, "R1 R2 R4 fmt0 16-bit");
    run_pair(3'd0, 24'h001234, 24'h00C321, 4, 0, "R2 R4 fmt0 second");
    run_pair(3'd2, 24'hF80000, 24'h07ABCD, 4, 0, "R2 R4 fmt2 20-bit");
    run_pair(3'd1, 24'h800001, 24'h5A5A5A, 4, 0, "R2 fmt1 24-bit");
    run_pair(3'd3, 24'hC0FFEE, 24'h123456, 4, 0, "R3 fmt3 left-justified");
    run_pair(3'd4, 24'h3A5C7E, 24'hFEDCBA, 4, 0, "R3 fmt4 left-justified");
  endtask

  task automatic t_ratio384;
    ratio_384 = 1'b1;
    run_pair(3'd1, 24'hA1B2C3, 24'h4D5E6F, 6, 0, "R8 ratio 384");
    ratio_384 = 1'b0;
    run_pair(3'd1, 24'h0F0F0F, 24'hF0F0F0, 4, 0, "R8 ratio 256");
  endtask

  task automatic t_ext;
    fmt_sel = 3'd1;
    send_frame(24'h111111, 24'h222222, 6, 1);
    chk(ext_bclk_mode == 0, "R6 mode held until frame closes", ext_bclk_mode, 0);
    run_pair(3'd1, 24'h9ABCDE, 24'h654321, 6, 1, "R7 external bit clock");
    chk(ext_bclk_mode == 1, "R6 external mode detected", ext_bclk_mode, 1);
    // Bit clock stops: the frame closing brings one level change only.
    send_frame(24'h333333, 24'h444444, 4, 0);
    chk(ext_bclk_mode == 1, "R6 mode held during idle frame", ext_bclk_mode, 1);
    run_pair(3'd1, 24'h76A5B4, 24'h8C9DAE, 4, 0, "R6 R8 back to internal");
    chk(ext_bclk_mode == 0, "R6 reverted to internal", ext_bclk_mode, 0);
  endtask

  task automatic t_reserved;
    int v0;
    logic [23:0] hl, hr;
    fmt_sel = 3'd5;
    v0 = vcnt;
    hl = left_out;
    hr = right_out;
    send_frame(24'h777777, 24'h888888, 4, 0);
    fmt_sel = 3'd7;
    send_frame(24'h999999, 24'hAAAAAA, 4, 0);
    send_frame(24'hBBBBBB, 24'hCCCCCC, 4, 0);
    chk(vcnt == v0, "R10 no strobe for reserved codes", vcnt - v0, 0);
    chk(left_out == hl && right_out == hr, "R10 outputs hold", {8'd0, left_out}, {8'd0, hl});
  endtask

  initial begin
    t_reset;
    t_holdoff;
    t_formats;
    t_ratio384;
    t_ext;
    t_reserved;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule